// File: doc/BRIEF.md
# Real-Mode Call/Return Stack Sequencer

This block carries out the stack traffic for the real-mode control transfers that move return state through memory. It handles near return, near return with stack release, far return, far return with stack release, far call and interrupt return. After a single start pulse it latches the operation and its operands. It then runs the pops or pushes over a 16-bit word memory port, one access at a time, and each access waits for a ready handshake.

While the operation runs, the block works on a private, speculative copy of the stack pointer. Once the transfers are complete, the new instruction pointer is compared with the code-segment limit. If every check passes, the block commits IP, the CS selector, FLAGS and the stack pointer in a single cycle. If a check fails, it aborts and writes nothing. In both cases a one-cycle done strobe carries a fault code.

The stack-size input selects how the pointer is treated. When it is set, the pointer is a 32-bit value. When it is clear, it is a 16-bit value whose upper half is carried along unchanged.

Top module: `rm_stack_seq`

## Requirements
- R1: Operation code 0 is a near return and code 1 is a near return with release. Each reads one word at the stack pointer as the new IP and advances the pointer by 2. Code 1 then adds the 16-bit immediate, zero-extended, to the pointer. Code 0 ignores the immediate. Only IP and the stack pointer are committed.
- R2: Operation codes 2 and 3 are far returns. They read IP from the current pointer and CS from the next word up, for a total advance of 4. Code 3 then adds the immediate, and code 2 ignores it.
- R3: Operation code 5 is an interrupt return. It reads IP, then CS, then FLAGS from three ascending words, for a total advance of 6. All 16 popped FLAGS bits are committed.
- R4: Operation code 4 is a far call. It writes the current CS to pointer minus 2 and then the current IP to pointer minus 4, in that order. It then commits the target IP and target CS, with the pointer lowered by 4.
- R5: When the new IP, taken as an unsigned value, is greater than the CS limit, the operation ends with fault code 1 and no write enable is asserted. An IP equal to the limit passes.
- R6: With the stack-size bit set, every pointer change and every memory address uses all 32 bits. With the bit clear, only the low 16 bits change and they wrap modulo 65536. The upper half is kept, and the memory address is the low 16 bits zero-extended.
- R7: When mem_err is high together with mem_ready, the operation aborts at once with fault code 2 and no write enable. This fault takes priority over the limit check.
- R8: mem_req stays high, with address, direction and write data held stable, until mem_ready is seen. Results do not depend on the wait length.
- R9: done is high for exactly one cycle per operation. A fault code of 0 comes with IP and stack-pointer write enables. The write enables are never high without done. After reset, busy, mem_req and done are low.
- R10: A start pulse while the block is busy is ignored, and the running operation finishes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | Operation code (see R1 to R4) |
| imm | input | 16 | Stack release amount for codes 1 and 3 |
| cur_cs | input | 16 | Current CS selector (pushed by far call) |
| cur_ip | input | 16 | Return IP (pushed by far call) |
| cur_esp | input | 32 | Stack pointer before the operation |
| ss_big | input | 1 | Stack-size bit: 1 means 32-bit pointer arithmetic |
| cs_limit | input | 32 | Scaled code-segment limit |
| tgt_cs | input | 16 | Far call target selector |
| tgt_ip | input | 16 | Far call target IP |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a push write, 0 for a pop read |
| mem_addr | output | 32 | Stack offset of the access |
| mem_wdata | output | 16 | Push data |
| mem_rdata | input | 16 | Pop data, valid with mem_ready |
| mem_ready | input | 1 | Access complete |
| mem_err | input | 1 | Stack fault on this access, sampled with mem_ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| fault | output | 2 | 0 none, 1 limit fault, 2 stack fault |
| ip_we | output | 1 | Commit commit_ip |
| cs_we | output | 1 | Commit commit_cs |
| flags_we | output | 1 | Commit commit_flags |
| esp_we | output | 1 | Commit commit_esp |
| commit_ip | output | 16 | New IP |
| commit_cs | output | 16 | New CS selector |
| commit_flags | output | 16 | New FLAGS |
| commit_esp | output | 32 | New stack pointer |

## Verification
The assertions check the handshake on every cycle: a request is held stable until it is accepted, and a request appears only while the block is busy. They also check that done is a single pulse, that no write enable appears outside done or together with a fault, and that an accepted stack error is followed by a stack-fault abort. Only the bench scenarios can show the correct pop and push order, the popped values landing in IP, CS and FLAGS, and the limit comparison at its exact boundary. The same holds for the 16-bit wraparound against the 32-bit pointer arithmetic and for the priority of a stack fault over a limit fault. The bench sweeps every operation, both stack sizes, pointers placed to wrap in both directions, three limit placements and several wait lengths.

// File: rtl/rm_seq_pkg.sv
package rm_seq_pkg;

    localparam int MAX_WORDS  = 3;
    localparam int PLAN_CNT_W = $clog2(MAX_WORDS + 1);

    typedef enum logic [2:0] {
        OP_RET_NEAR     = 3'd0,
        OP_RET_NEAR_REL = 3'd1,
        OP_RET_FAR      = 3'd2,
        OP_RET_FAR_REL  = 3'd3,
        OP_CALL_FAR     = 3'd4,
        OP_IRET         = 3'd5
    } rm_op_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_GP    = 2'd1,
        FLT_STACK = 2'd2
    } rm_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_CHECK = 2'd2
    } rm_state_e;

    typedef struct packed {
        logic [PLAN_CNT_W-1:0] nwords;
        logic                  push;
        logic                  load_cs;
        logic                  load_flags;
        logic                  use_imm;
    } rm_plan_t;

endpackage

// File: rtl/rm_seq_plan.sv
module rm_seq_plan
    import rm_seq_pkg::*;
(
    input  logic [2:0] op,
    output rm_plan_t   plan
);
    always_comb begin
        plan = '0;
        case (op)
            OP_RET_NEAR_REL: begin
                plan.nwords  = PLAN_CNT_W'(1);
                plan.use_imm = 1'b1;
            end
            OP_RET_FAR: begin
                plan.nwords  = PLAN_CNT_W'(2);
                plan.load_cs = 1'b1;
            end
            OP_RET_FAR_REL: begin
                plan.nwords  = PLAN_CNT_W'(2);
                plan.load_cs = 1'b1;
                plan.use_imm = 1'b1;
            end
            OP_CALL_FAR: begin
                plan.nwords  = PLAN_CNT_W'(2);
                plan.push    = 1'b1;
                plan.load_cs = 1'b1;
            end
            OP_IRET: begin
                plan.nwords     = PLAN_CNT_W'(3);
                plan.load_cs    = 1'b1;
                plan.load_flags = 1'b1;
            end
            default: begin
                plan.nwords = PLAN_CNT_W'(1);
            end
        endcase
    end
endmodule

// File: rtl/rm_seq_sp.sv
module rm_seq_sp #(
    parameter int SP_W = 32,
    parameter int DW   = 16
) (
    input  logic [SP_W-1:0] base,
    input  logic [DW-1:0]   delta,
    input  logic            sext,
    input  logic            big,
    output logic [SP_W-1:0] result
);
    localparam int HI_W = SP_W - DW;

    logic [SP_W-1:0] ext;
    logic [DW-1:0]   low_sum;

    always_comb begin
        ext     = sext ? {{HI_W{delta[DW-1]}}, delta} : {{HI_W{1'b0}}, delta};
        low_sum = base[DW-1:0] + delta;
        if (big) begin
            result = base + ext;
        end else begin
            result = {base[SP_W-1:DW], low_sum};
        end
    end
endmodule

// File: rtl/rm_seq_limit.sv
module rm_seq_limit #(
    parameter int IP_W  = 16,
    parameter int LIM_W = 32
) (
    input  logic [IP_W-1:0]  ip,
    input  logic [LIM_W-1:0] limit,
    output logic             over
);
    always_comb begin
        over = LIM_W'(ip) > limit;
    end
endmodule

// File: rtl/rm_stack_seq.sv
module rm_stack_seq
    import rm_seq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SP_W   = 32,
    parameter int LIM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] imm,
    input  logic [WORD_W-1:0] cur_cs,
    input  logic [WORD_W-1:0] cur_ip,
    input  logic [SP_W-1:0]   cur_esp,
    input  logic              ss_big,
    input  logic [LIM_W-1:0]  cs_limit,
    input  logic [WORD_W-1:0] tgt_cs,
    input  logic [WORD_W-1:0] tgt_ip,
    output logic              mem_req,
    output logic              mem_we,
    output logic [SP_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    output logic              busy,
    output logic              done,
    output logic [1:0]        fault,
    output logic              ip_we,
    output logic              cs_we,
    output logic              flags_we,
    output logic              esp_we,
    output logic [WORD_W-1:0] commit_ip,
    output logic [WORD_W-1:0] commit_cs,
    output logic [WORD_W-1:0] commit_flags,
    output logic [SP_W-1:0]   commit_esp
);
    localparam logic [WORD_W-1:0] POP_STEP  = WORD_W'(2);
    localparam logic [WORD_W-1:0] PUSH_STEP = ~WORD_W'(1);

    typedef struct packed {
        rm_state_e                         st;
        logic [PLAN_CNT_W-1:0]             idx;
        logic [SP_W-1:0]                   sp;
        rm_plan_t                          plan;
        logic [WORD_W-1:0]                 imm;
        logic                              big;
        logic [LIM_W-1:0]                  limit;
        logic [WORD_W-1:0]                 push_cs;
        logic [WORD_W-1:0]                 push_ip;
        logic [WORD_W-1:0]                 tgt_cs;
        logic [WORD_W-1:0]                 tgt_ip;
        logic [MAX_WORDS-1:0][WORD_W-1:0]  words;
        logic                              done;
        rm_fault_e                         fault;
        logic                              ip_we;
        logic                              cs_we;
        logic                              flags_we;
        logic                              esp_we;
        logic [WORD_W-1:0]                 c_ip;
        logic [WORD_W-1:0]                 c_cs;
        logic [WORD_W-1:0]                 c_flags;
        logic [SP_W-1:0]                   c_esp;
    } seq_t;

    seq_t q, d;

    rm_plan_t          plan_in;
    logic [SP_W-1:0]   step_sp;
    logic [SP_W-1:0]   rel_sp;
    logic [SP_W-1:0]   addr_src;
    logic [WORD_W-1:0] ip_sel;
    logic              ip_over;
    logic              last_word;

    rm_seq_plan u_plan (
        .op   (op),
        .plan (plan_in)
    );

    // pointer move for one word: +2 for pop, -2 for push
    rm_seq_sp #(.SP_W(SP_W), .DW(WORD_W)) u_step (
        .base   (q.sp),
        .delta  (q.plan.push ? PUSH_STEP : POP_STEP),
        .sext   (q.plan.push),
        .big    (q.big),
        .result (step_sp)
    );

    // stack release by the immediate
    rm_seq_sp #(.SP_W(SP_W), .DW(WORD_W)) u_rel (
        .base   (q.sp),
        .delta  (q.imm),
        .sext   (1'b0),
        .big    (q.big),
        .result (rel_sp)
    );

    rm_seq_limit #(.IP_W(WORD_W), .LIM_W(LIM_W)) u_limit (
        .ip    (ip_sel),
        .limit (q.limit),
        .over  (ip_over)
    );

    always_comb begin
        ip_sel    = q.plan.push ? q.tgt_ip : q.words[0];
        last_word = (q.idx == q.plan.nwords - PLAN_CNT_W'(1));
        addr_src  = q.plan.push ? step_sp : q.sp;
    end

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.ip_we    = 1'b0;
        d.cs_we    = 1'b0;
        d.flags_we = 1'b0;
        d.esp_we   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_XFER;
                    d.idx     = '0;
                    d.sp      = cur_esp;
                    d.plan    = plan_in;
                    d.imm     = imm;
                    d.big     = ss_big;
                    d.limit   = cs_limit;
                    d.push_cs = cur_cs;
                    d.push_ip = cur_ip;
                    d.tgt_cs  = tgt_cs;
                    d.tgt_ip  = tgt_ip;
                    d.words   = '0;
                end
            end
            ST_XFER: begin
                if (mem_ready) begin
                    if (mem_err) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.fault = FLT_STACK;
                    end else begin
                        if (!q.plan.push) begin
                            d.words[q.idx] = mem_rdata;
                        end
                        d.sp = step_sp;
                        if (last_word) begin
                            d.st = ST_CHECK;
                        end else begin
                            d.idx = q.idx + PLAN_CNT_W'(1);
                        end
                    end
                end
            end
            ST_CHECK: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                if (ip_over) begin
                    d.fault = FLT_GP;
                end else begin
                    d.fault    = FLT_NONE;
                    d.ip_we    = 1'b1;
                    d.cs_we    = q.plan.load_cs;
                    d.flags_we = q.plan.load_flags;
                    d.esp_we   = 1'b1;
                    d.c_ip     = ip_sel;
                    d.c_cs     = q.plan.push ? q.tgt_cs : q.words[1];
                    d.c_flags  = q.words[2];
                    d.c_esp    = q.plan.use_imm ? rel_sp : q.sp;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy         = (q.st != ST_IDLE);
        mem_req      = (q.st == ST_XFER);
        mem_we       = q.plan.push;
        mem_addr     = q.big ? addr_src : SP_W'(addr_src[WORD_W-1:0]);
        mem_wdata    = (q.idx == '0) ? q.push_cs : q.push_ip;
        done         = q.done;
        fault        = q.fault;
        ip_we        = q.ip_we;
        cs_we        = q.cs_we;
        flags_we     = q.flags_we;
        esp_we       = q.esp_we;
        commit_ip    = q.c_ip;
        commit_cs    = q.c_cs;
        commit_flags = q.c_flags;
        commit_esp   = q.c_esp;
    end
endmodule

// File: rtl/rm_stack_seq_chk.sv
module rm_stack_seq_chk #(
    parameter int WORD_W = 16,
    parameter int SP_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic [SP_W-1:0]   mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              mem_err,
    input logic              done,
    input logic [1:0]        fault,
    input logic              ip_we,
    input logic              cs_we,
    input logic              flags_we,
    input logic              esp_we
);
    logic any_we;
    assign any_we = ip_we | cs_we | flags_we | esp_we;

    AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy) else $error("AST_REQ_WHEN_BUSY"); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata))) else $error("AST_REQ_HELD"); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("AST_DONE_PULSE"); // R9

    AST_WE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        any_we |-> done) else $error("AST_WE_NEEDS_DONE"); // R9

    AST_OK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault == 2'd0) |-> (ip_we && esp_we)) else $error("AST_OK_COMMITS"); // R9

    AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault != 2'd0) |-> !any_we) else $error("AST_ABORT_CLEAN"); // R5

    AST_STACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err) |=> (done && fault == 2'd2)) else $error("AST_STACK_ABORT"); // R7

    AST_FLAGS_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> cs_we) else $error("AST_FLAGS_WITH_CS"); // R3

endmodule

bind rm_stack_seq rm_stack_seq_chk #(.WORD_W(WORD_W), .SP_W(SP_W)) u_chk (.*);

// File: tb/rm_stack_seq_bench.sv
`timescale 1ns/1ps
module rm_stack_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [15:0] imm = '0, cur_cs = '0, cur_ip = '0, tgt_cs = '0, tgt_ip = '0;
    logic [31:0] cur_esp = '0, cs_limit = '0;
    logic        ss_big = 1'b0;
    logic        mem_req, mem_we, busy, done;
    logic [31:0] mem_addr, commit_esp;
    logic [15:0] mem_wdata, commit_ip, commit_cs, commit_flags;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0, mem_err = 1'b0;
    logic [1:0]  fault;
    logic        ip_we, cs_we, flags_we, esp_we;

    int tests = 0, fails = 0;
    int lat = 0, err_abs = -1, wait_cnt = 0, acc_total = 0, wr_total = 0;
    logic [31:0] wr_addr [4];
    logic [15:0] wr_data [4];

    always #4 clk = ~clk;

    rm_stack_seq u_rm_stack_seq (.*);

    function automatic logic [15:0] pat(input logic [31:0] a);
        return a[15:0] * 16'h2F1B + a[31:16] + 16'h1357;
    endfunction

    function automatic logic [31:0] adj(input logic [31:0] s, input logic [31:0] dl, input logic big);
        logic [15:0] lo;
        lo = s[15:0] + dl[15:0];
        return big ? s + dl : {s[31:16], lo};
    endfunction

    function automatic logic [31:0] eaddr(input logic [31:0] s, input logic big);
        return big ? s : {16'h0, s[15:0]};
    endfunction

    // memory responder: ready after lat idle cycles, stack error on a chosen access
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0; mem_err = 1'b0; wait_cnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0; mem_err = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                wait_cnt  = 0;
                mem_ready = 1'b1;
                mem_err   = (acc_total == err_abs);
                if (mem_we) begin
                    if (!mem_err) begin
                        wr_addr[wr_total % 4] = mem_addr;
                        wr_data[wr_total % 4] = mem_wdata;
                        wr_total++;
                    end
                end else begin
                    mem_rdata = pat(mem_addr);
                end
                acc_total++;
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] o, input logic big, input logic [31:0] esp,
                          input logic [15:0] im, input int lim_mode, input int lt,
                          input int ea, input bit poke);
        int n, wbase, guard;
        logic push;
        logic [31:0] sp, lim, wa0, wa1;
        logic [15:0] v [3];
        logic [15:0] ipx, ccs, cip, tcs, tip;
        logic [1:0]  efault;
        string tag;
        n    = (o == 3'd5) ? 3 : (o >= 3'd2) ? 2 : 1;
        push = (o == 3'd4);
        tag  = (o <= 3'd1) ? "R1" : (o <= 3'd3) ? "R2" : (o == 3'd4) ? "R4" : "R3";
        ccs  = 16'hB800; cip = 16'h1234 + esp[15:0];
        tcs  = 16'h7C00; tip = 16'h4321 + {8'h0, esp[7:0]};
        sp   = esp; wa0 = '0; wa1 = '0;
        for (int k = 0; k < 3; k++) v[k] = '0;
        if (push) begin
            sp = adj(sp, 32'hFFFF_FFFE, big); wa0 = eaddr(sp, big);
            sp = adj(sp, 32'hFFFF_FFFE, big); wa1 = eaddr(sp, big);
            ipx = tip;
        end else begin
            for (int k = 0; k < n; k++) begin
                v[k] = pat(eaddr(sp, big));
                sp = adj(sp, 32'd2, big);
            end
            ipx = v[0];
        end
        if (o == 3'd1 || o == 3'd3) sp = adj(sp, {16'h0, im}, big);
        lim = (lim_mode == 0) ? {16'h0, ipx} - 32'd1 : (lim_mode == 1) ? {16'h0, ipx} : 32'h000F_FFFF;
        efault = (ea < n) ? 2'd2 : ({16'h0, ipx} > lim) ? 2'd1 : 2'd0;

        @(negedge clk);
        op = o; ss_big = big; cur_esp = esp; imm = im; cs_limit = lim;
        cur_cs = ccs; cur_ip = cip; tgt_cs = tcs; tgt_ip = tip;
        lat = lt; err_abs = acc_total + ea; wbase = wr_total;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            start = 1'b1; op = 3'd4; cur_esp = ~esp; imm = 16'h0F0F; ss_big = ~big;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        if (!done) begin
            tests++; fails++;
            $display("FAIL R9 no done strobe actual=0 expected=1");
        end
        chk({tag, " R8 fault code", (efault == 2'd2) ? " R7" : " R5"}, fault, efault);
        if (efault != 2'd0) begin
            chk((efault == 2'd2) ? "R7 no commit on stack fault" : "R5 no commit on limit fault",
                {ip_we, cs_we, flags_we, esp_we}, 4'b0000);
        end else begin
            chk({tag, " ip commit"}, {ip_we, commit_ip}, {1'b1, ipx});
            chk({tag, " cs enable"}, cs_we, (o >= 3'd2));
            if (o >= 3'd2) chk({tag, " cs value"}, commit_cs, push ? tcs : v[1]);
            chk("R3 flags enable", flags_we, (o == 3'd5));
            if (o == 3'd5) chk("R3 flags value", commit_flags, v[2]);
            chk({tag, " R6 stack pointer"}, {esp_we, commit_esp}, {1'b1, sp});
            if (poke) chk("R10 start ignored while busy", commit_esp, sp);
            if (push) begin
                chk("R4 push count", wr_total - wbase, 2);
                chk("R4 R6 first push addr", wr_addr[wbase % 4], wa0);
                chk("R4 first push data", wr_data[wbase % 4], ccs);
                chk("R4 R6 second push addr", wr_addr[(wbase + 1) % 4], wa1);
                chk("R4 second push data", wr_data[(wbase + 1) % 4], cip);
            end
        end
        @(negedge clk);
        chk("R9 done single cycle", done, 1'b0);
    endtask

    initial begin
        #2_000_000;
        tests++; fails++;
        $display("FAIL R9 watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] esps [3];
        esps[0] = 32'h0000_0100;
        esps[1] = 32'h0001_FFFE;
        esps[2] = 32'h0003_0000;
        repeat (3) @(negedge clk);
        chk("R9 reset state", {busy, mem_req, done}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int o = 0; o < 6; o++)
            for (int b = 0; b < 2; b++)
                for (int e = 0; e < 3; e++)
                    for (int m = 0; m < 3; m++)
                        run_op(3'(o), b[0], esps[e], (e == 1) ? 16'hFFF4 : 16'h0010,
                               m, (o + b + m + e) % 3, 99, 1'b0);
        // stack fault on each access, limit also violated: stack fault wins
        for (int o = 0; o < 6; o++) begin
            int nw;
            nw = (o == 5) ? 3 : (o >= 2) ? 2 : 1;
            for (int k = 0; k < nw; k++)
                run_op(3'(o), k[0], esps[k % 3], 16'h0010, 0, k, k, 1'b0);
        end
        run_op(3'd2, 1'b0, 32'h0000_0200, 16'h0000, 2, 3, 99, 1'b1);
        run_op(3'd5, 1'b1, 32'h0000_0300, 16'h0000, 1, 3, 99, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule